// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Port

This block sits between an external debugger on an APB bus and a halted core. The debugger writes opcodes into an instruction latch, which the block hands to the core over a one-cycle issue strobe. Two single-entry mailboxes carry data. The host-to-core mailbox is written by the debugger and drained by the core. The core-to-host mailbox is filled by the core and drained by the debugger. A status word reports instruction completion, mailbox occupancy, two sticky abort flags and the current transfer mode. A control word clears the abort flags.

The transfer mode sets how APB accesses behave. In normal mode an access never waits. In stall mode PREADY is held low until the target resource is ready, so the debugger does not have to poll between transfers. Fast mode does the same waiting. In addition, it only latches an opcode written to the instruction register and then reissues that opcode on every mailbox access. A block read or write therefore costs one APB access per data word.

Top module: `dbg_xfer`

## Requirements
- R1: After reset the mode is normal, both mailboxes are empty, both abort flags are clear and the completion flag (status bit 24) is 1.
- R2: Registers sit at byte addresses of word offset times four. Word 32 is the core-to-host mailbox (read). Word 33 is the instruction latch (write). Word 34 is status. Word 35 is the host-to-core mailbox (write). Word 36 is control (write). In the status word, bit 6 and bit 7 are the abort flags, bits 21:20 are the mode, bit 24 is completion, bit 29 means the core-to-host mailbox holds data and bit 30 means the host-to-core mailbox is full.
- R3: When the mode field is 00 or 11 (normal), PREADY never drops. An instruction write issues the opcode on the issue port in the cycle after the access completes. A mailbox read with no data returns the previous value and leaves the status unchanged. A mailbox write with the mailbox already full replaces the old data.
- R4: A debugger read of the core-to-host mailbox clears status bit 29. A core read of the host-to-core mailbox clears status bit 30.
- R5: Status bit 24 drops when an opcode issues and returns when the core pulses done_i.
- R6: In mode 01 (stall), an instruction write waits until the previously issued instruction has completed, and then issues.
- R7: In stall mode, a core-to-host read waits until that mailbox holds data. A host-to-core write waits until that mailbox is empty.
- R8: In mode 10 (fast), an instruction write completes at once and latches the opcode without issuing it.
- R9: In fast mode, each core-to-host read waits for data and for completion of the previous instruction. Each host-to-core write waits for an empty mailbox and for completion. Each such access then reissues the latched opcode.
- R10: abort_i[0] sets status bit 6 and abort_i[1] sets status bit 7. Each flag stays set until it is cleared.
- R11: A control write with bit 2 set clears both abort flags. A control write with bit 2 clear leaves them unchanged.
- R12: While either abort flag is set, no opcode is issued or reissued, and no access waits.
- R13: A status write changes only the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| pready_o | output | 1 | APB ready; low extends the access |
| issue_valid_o | output | 1 | One-cycle strobe: an opcode is handed to the core |
| issue_op_o | output | DATA_W | Opcode being issued |
| done_i | input | 1 | Core signals that the issued instruction has finished |
| abort_i | input | 2 | Memory abort indications that set the sticky flags |
| core_rx_rd_i | input | 1 | Core takes the host-to-core mailbox word |
| core_rx_data_o | output | DATA_W | Host-to-core mailbox contents |
| core_rx_full_o | output | 1 | Host-to-core mailbox holds data |
| core_tx_wr_i | input | 1 | Core writes the core-to-host mailbox |
| core_tx_data_i | input | DATA_W | Data the core writes |
| core_tx_full_o | output | 1 | Core-to-host mailbox holds data |

## Verification
A wrong mode decode, or a wrong view of busy or occupancy, shows up as a PREADY wait count that is wrong on the very access where it happens. In the worst case the access hangs and the bench's wait limit catches it. A lost or extra reissue in fast mode shifts the data stream: a block read returns a word from the wrong address, or a block write lands in the wrong memory slot, within one word of the fault. A stuck abort flag is visible at once in the status word, and it also shows through the issue-strobe count at the port.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_STALL  = 2'b01,
    XM_FAST   = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  localparam int unsigned WO_TX   = 32;
  localparam int unsigned WO_OP   = 33;
  localparam int unsigned WO_STAT = 34;
  localparam int unsigned WO_RX   = 35;
  localparam int unsigned WO_CTRL = 36;

  localparam int unsigned B_ABT0  = 6;
  localparam int unsigned B_ABT1  = 7;
  localparam int unsigned B_MODE  = 20;
  localparam int unsigned B_DONE  = 24;
  localparam int unsigned B_TXV   = 29;
  localparam int unsigned B_RXF   = 30;
  localparam int unsigned B_CLR   = 2;
endpackage

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      full_o <= 1'b1;
      data_o <= wdata_i;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end

  // R4
  rd_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> !full_o);
endmodule

// File: rtl/dbg_issue_ctl.sv
module dbg_issue_ctl #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         latch_i,
  input  logic [W-1:0] op_i,
  input  logic         fire_i,
  input  logic         done_i,
  input  logic [1:0]   abort_i,
  input  logic         clr_abort_i,
  output logic         issue_valid_o,
  output logic [W-1:0] issue_op_o,
  output logic         busy_o,
  output logic [1:0]   sticky_o
);
  logic [W-1:0] op_q;
  logic         fire_ok;

  // aborted state suppresses every issue
  assign fire_ok = fire_i && (sticky_o == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q          <= '0;
      issue_valid_o <= 1'b0;
      issue_op_o    <= '0;
      busy_o        <= 1'b0;
      sticky_o      <= 2'b00;
    end else begin
      if (latch_i) op_q <= op_i;
      issue_valid_o <= fire_ok;
      if (fire_ok) issue_op_o <= latch_i ? op_i : op_q;
      if (fire_ok)     busy_o <= 1'b1;
      else if (done_i) busy_o <= 1'b0;
      sticky_o <= (sticky_o & ~{2{clr_abort_i}}) | abort_i;
    end
  end

  // R12
  abort_blocks_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_o != 2'b00) |=> !issue_valid_o);
  // R5
  issue_marks_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> busy_o);
  // R10
  abort_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i != 2'b00) |=> ((sticky_o & $past(abort_i)) == $past(abort_i)));
  // R11
  clear_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_abort_i && abort_i == 2'b00) |=> (sticky_o == 2'b00));
endmodule

// File: rtl/dbg_xfer.sv
module dbg_xfer
  import dbg_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              issue_valid_o,
  output logic [DATA_W-1:0] issue_op_o,
  input  logic              done_i,
  input  logic [1:0]        abort_i,
  input  logic              core_rx_rd_i,
  output logic [DATA_W-1:0] core_rx_data_o,
  output logic              core_rx_full_o,
  input  logic              core_tx_wr_i,
  input  logic [DATA_W-1:0] core_tx_data_i,
  output logic              core_tx_full_o
);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(WO_TX * 4);
  localparam logic [ADDR_W-1:0] A_OP   = ADDR_W'(WO_OP * 4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(WO_STAT * 4);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(WO_RX * 4);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(WO_CTRL * 4);

  xfer_mode_e        mode_q;
  logic              access, xfer_done, abt, busy, is_stall, is_fast;
  logic              hit_tx, hit_op, hit_stat, hit_rx, hit_ctrl;
  logic              op_wr, tx_rd, rx_wr, clr_abort, fire;
  logic [1:0]        sticky;
  logic [DATA_W-1:0] tx_data, stat_word;

  assign access   = psel_i && penable_i;
  assign hit_tx   = (paddr_i == A_TX);
  assign hit_op   = (paddr_i == A_OP);
  assign hit_stat = (paddr_i == A_STAT);
  assign hit_rx   = (paddr_i == A_RX);
  assign hit_ctrl = (paddr_i == A_CTRL);
  assign is_stall = (mode_q == XM_STALL);
  assign is_fast  = (mode_q == XM_FAST);
  assign abt      = |sticky;

  always_comb begin
    pready_o = 1'b1;
    if (access && !abt) begin
      if (pwrite_i && hit_op && is_stall) pready_o = !busy;
      if (!pwrite_i && hit_tx) begin
        if (is_stall)     pready_o = core_tx_full_o;
        else if (is_fast) pready_o = core_tx_full_o && !busy;
      end
      if (pwrite_i && hit_rx) begin
        if (is_stall)     pready_o = !core_rx_full_o;
        else if (is_fast) pready_o = !core_rx_full_o && !busy;
      end
    end
  end

  assign xfer_done = access && pready_o;
  assign op_wr     = xfer_done && pwrite_i && hit_op;
  assign tx_rd     = xfer_done && !pwrite_i && hit_tx;
  assign rx_wr     = xfer_done && pwrite_i && hit_rx;
  assign clr_abort = xfer_done && pwrite_i && hit_ctrl && pwdata_i[B_CLR];
  assign fire      = (op_wr && !is_fast) || (is_fast && (tx_rd || rx_wr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= XM_NORMAL;
    else if (xfer_done && pwrite_i && hit_stat)
      mode_q <= xfer_mode_e'(pwdata_i[B_MODE+1:B_MODE]);
  end

  always_comb begin
    stat_word = '0;
    stat_word[B_ABT0] = sticky[0];
    stat_word[B_ABT1] = sticky[1];
    stat_word[B_MODE+1:B_MODE] = mode_q;
    stat_word[B_DONE] = !busy;
    stat_word[B_TXV]  = core_tx_full_o;
    stat_word[B_RXF]  = core_rx_full_o;
  end

  always_comb begin
    prdata_o = '0;
    if (hit_tx)        prdata_o = tx_data;
    else if (hit_stat) prdata_o = stat_word;
  end

  dbg_mailbox #(.W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .wr_i(core_tx_wr_i), .wdata_i(core_tx_data_i), .rd_i(tx_rd),
    .full_o(core_tx_full_o), .data_o(tx_data)
  );

  dbg_mailbox #(.W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .wr_i(rx_wr), .wdata_i(pwdata_i), .rd_i(core_rx_rd_i),
    .full_o(core_rx_full_o), .data_o(core_rx_data_o)
  );

  dbg_issue_ctl #(.W(DATA_W)) u_issue (
    .clk_i, .rst_ni,
    .latch_i(op_wr), .op_i(pwdata_i), .fire_i(fire), .done_i,
    .abort_i, .clr_abort_i(clr_abort),
    .issue_valid_o, .issue_op_o, .busy_o(busy), .sticky_o(sticky)
  );

  // R3
  normal_nowait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pready_o |-> (is_stall || is_fast));
  // R12
  abort_nowait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && abt) |-> pready_o);
  // R8
  fast_latch_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_wr && is_fast && !tx_rd && !rx_wr) |=> !issue_valid_o);
  // R13
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_done && pwrite_i && hit_stat) |=> $stable(mode_q));
endmodule

// File: tb/tb_dbg_xfer.sv
module tb_dbg_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata, issue_op, rx_data;
  logic        pready, issue_valid, rx_full, tx_full;
  logic        done = 0, rx_rd = 0, tx_wr = 0;
  logic [1:0]  abort = 0;
  logic [31:0] tx_data = 0;

  int n_chk = 0, n_bad = 0, n_issue = 0;
  logic [31:0] regs [16];
  logic [31:0] mem  [64];

  localparam int LAT = 6;
  localparam logic [7:0] A_TX = 8'h80, A_OP = 8'h84, A_ST = 8'h88, A_RX = 8'h8C, A_CT = 8'h90;
  localparam logic [31:0] M_NORM = 32'h0, M_STALL = 32'h0010_0000, M_FAST = 32'h0020_0000;

  always #4 clk = ~clk;

  dbg_xfer dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .issue_valid_o(issue_valid), .issue_op_o(issue_op), .done_i(done), .abort_i(abort),
    .core_rx_rd_i(rx_rd), .core_rx_data_o(rx_data), .core_rx_full_o(rx_full),
    .core_tx_wr_i(tx_wr), .core_tx_data_i(tx_data), .core_tx_full_o(tx_full)
  );

  function automatic logic [31:0] op(input int kind, input int idx);
    return {kind[3:0], 24'h0, idx[3:0]};
  endfunction

  // core stub: 1 push reg, 2 pop into reg, 3 load [r0]+4, 4 store [r0]+4, 5 abort0, 6 abort1
  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'hA000_0000 + i * 32'h111;
    for (int i = 0; i < 64; i++) mem[i] = 32'hC000_0000 + i * 7;
    forever begin
      @(negedge clk);
      if (issue_valid) begin
        logic [31:0] o;
        o = issue_op;
        n_issue++;
        repeat (LAT - 1) @(negedge clk);
        case (o[31:28])
          4'd1: begin tx_data = regs[o[3:0]]; tx_wr = 1; end
          4'd2: begin regs[o[3:0]] = rx_data; rx_rd = 1; end
          4'd3: begin tx_data = mem[regs[0][7:2]]; tx_wr = 1; regs[0] = regs[0] + 4; end
          4'd4: begin mem[regs[0][7:2]] = rx_data; rx_rd = 1; regs[0] = regs[0] + 4; end
          4'd5: abort = 2'b01;
          4'd6: abort = 2'b10;
          default: ;
        endcase
        done = 1;
        @(negedge clk);
        done = 0; tx_wr = 0; rx_rd = 0; abort = 0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int waits);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    waits = 0;
    q = '0;
    forever begin
      #1;
      if (pready) begin q = prdata; break; end
      @(negedge clk);
      waits++;
      if (waits > 1000) begin
        n_chk++; n_bad++;
        $display("FAIL hang: actual wait %0d expected <1000", waits);
        break;
      end
    end
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int w);
    logic [31:0] q;
    apb(1'b1, a, d, q, w);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q, output int w);
    apb(1'b0, a, 32'h0, q, w);
  endtask

  task automatic poll(input int b, input logic v);
    logic [31:0] s;
    int w;
    for (int i = 0; i < 200; i++) begin
      rd(A_ST, s, w);
      if (s[b] == v) return;
    end
    check("poll", {31'h0, ~v}, {31'h0, v});
  endtask

  task automatic t_reset;
    logic [31:0] s; int w;
    rd(A_ST, s, w);
    // R1 R2: only completion bit set
    check("R1 reset status", s, 32'h0100_0000);
    check("R1 wait", w, 0);
  endtask

  task automatic t_normal;
    logic [31:0] s, q; int w, c;
    c = n_issue;
    wr(A_OP, op(1, 5), w);
    check("R3 no wait op", w, 0);
    repeat (2) @(negedge clk);
    rd(A_ST, s, w);
    check("R5 done low while busy", {31'h0, s[24]}, 0);
    poll(24, 1);
    check("R3 one issue", n_issue - c, 1);
    rd(A_ST, s, w);
    check("R2 tx valid bit29", {31'h0, s[29]}, 1);
    rd(A_TX, q, w);
    check("R3 tx data", q, 32'hA000_0555);
    rd(A_ST, s, w);
    check("R4 tx read clears bit29", {31'h0, s[29]}, 0);
    rd(A_TX, q, w);
    check("R3 stale data", q, 32'hA000_0555);
    check("R3 stale no wait", w, 0);
    rd(A_ST, q, w);
    check("R3 status unchanged", q, s);
    wr(A_RX, 32'h1111_0001, w);
    wr(A_RX, 32'h2222_0002, w);
    check("R3 rx overwrite no wait", w, 0);
    rd(A_ST, s, w);
    check("R2 rx full bit30", {31'h0, s[30]}, 1);
    wr(A_OP, op(2, 9), w);
    poll(24, 1);
    rd(A_ST, s, w);
    check("R4 core pop clears bit30", {31'h0, s[30]}, 0);
    check("R3 overwritten word kept", regs[9], 32'h2222_0002);
  endtask

  task automatic t_status_write;
    logic [31:0] s; int w;
    wr(A_ST, 32'hFFFF_FFFF, w);
    rd(A_ST, s, w);
    check("R13 only mode field", s, 32'h0130_0000);
    wr(A_RX, 32'h3, w);
    wr(A_RX, 32'h4, w);
    check("R3 mode 11 acts normal", w, 0);
    wr(A_OP, op(2, 10), w);
    poll(24, 1);
    wr(A_ST, M_NORM, w);
  endtask

  task automatic t_stall;
    logic [31:0] q; int w;
    wr(A_ST, M_STALL, w);
    wr(A_OP, op(1, 5), w);
    wr(A_OP, op(1, 6), w);
    check("R6 op write waits", {31'h0, w > 0}, 1);
    rd(A_TX, q, w);
    check("R7 first word", q, 32'hA000_0555);
    rd(A_TX, q, w);
    check("R7 tx read waits", {31'h0, w > 0}, 1);
    check("R7 second word", q, 32'hA000_0666);
    wr(A_RX, 32'h5555_0005, w);
    wr(A_OP, op(2, 7), w);
    wr(A_RX, 32'h6666_0006, w);
    check("R7 rx write waits", {31'h0, w > 0}, 1);
    wr(A_OP, op(2, 8), w);
    wr(A_OP, op(1, 7), w);
    rd(A_TX, q, w);
    check("R7 first rx word", q, 32'h5555_0005);
    wr(A_OP, op(1, 8), w);
    rd(A_TX, q, w);
    check("R7 second rx word", q, 32'h6666_0006);
  endtask

  task automatic t_fast_read;
    logic [31:0] q; int w, c;
    localparam int N = 5;
    // still stall mode: load address into r0, start load
    wr(A_RX, 32'h20, w);
    wr(A_OP, op(2, 0), w);
    c = n_issue;
    wr(A_OP, op(3, 0), w);
    wr(A_ST, M_FAST, w);
    for (int k = 0; k < N - 1; k++) begin
      rd(A_TX, q, w);
      check("R9 fast read data", q, 32'hC000_0000 + (8 + k) * 7);
    end
    wr(A_ST, M_NORM, w);
    poll(29, 1);
    rd(A_TX, q, w);
    check("R9 last word", q, 32'hC000_0000 + (8 + N - 1) * 7);
    check("R9 issue count", n_issue - c, N);
    check("R9 address advanced", regs[0], 32'h20 + 4 * N);
  endtask

  task automatic t_fast_write;
    logic [31:0] s; int w, c;
    localparam int N = 4;
    wr(A_RX, 32'h80, w);
    wr(A_OP, op(2, 0), w);
    poll(24, 1);
    wr(A_ST, M_FAST, w);
    c = n_issue;
    wr(A_OP, op(4, 0), w);
    check("R8 no wait", w, 0);
    repeat (10) @(negedge clk);
    check("R8 latched not issued", n_issue - c, 0);
    rd(A_ST, s, w);
    check("R8 done stays", {31'h0, s[24]}, 1);
    for (int k = 0; k < N; k++) wr(A_RX, 32'hD000_0000 + k, w);
    wr(A_ST, M_NORM, w);
    poll(24, 1);
    poll(30, 0);
    check("R9 reissue count", n_issue - c, N);
    for (int k = 0; k < N; k++)
      check("R9 stored word", mem[32 + k], 32'hD000_0000 + k);
  endtask

  task automatic t_abort;
    logic [31:0] s, q; int w, c;
    wr(A_OP, op(5, 0), w);
    poll(24, 1);
    rd(A_ST, s, w);
    check("R10 flag bit6", {30'h0, s[7:6]}, 2'b01);
    c = n_issue;
    wr(A_OP, op(1, 3), w);
    repeat (12) @(negedge clk);
    check("R12 no issue", n_issue - c, 0);
    wr(A_ST, M_STALL, w);
    rd(A_TX, q, w);
    check("R12 stall bypass", w, 0);
    wr(A_ST, M_FAST, w);
    wr(A_RX, 32'h7, w);
    repeat (12) @(negedge clk);
    check("R12 no reissue", n_issue - c, 0);
    wr(A_ST, M_NORM, w);
    wr(A_CT, 32'hFFFF_FFFB, w);
    rd(A_ST, s, w);
    check("R11 bit2 clear no effect", {30'h0, s[7:6]}, 2'b01);
    wr(A_CT, 32'h4, w);
    rd(A_ST, s, w);
    check("R11 flags cleared", {30'h0, s[7:6]}, 2'b00);
    wr(A_OP, op(2, 11), w);
    poll(24, 1);
    wr(A_OP, op(6, 0), w);
    poll(24, 1);
    rd(A_ST, s, w);
    check("R10 flag bit7", {30'h0, s[7:6]}, 2'b10);
    wr(A_CT, 32'h4, w);
    rd(A_ST, s, w);
    check("R11 flags cleared again", {30'h0, s[7:6]}, 2'b00);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_normal();
    t_status_write();
    t_stall();
    t_fast_read();
    t_fast_write();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule